// File: doc/BRIEF.md
# Twenty-Cent Coin Vend Controller

This block is the control state machine of a vending machine that sells one item priced at twenty cents. It takes one nickel, dime or quarter on each clock edge where the coin strobe is high. Between coins it holds the credit already inserted as one of four values: 0, 5, 10 or 15 cents. The block is a Mealy machine, so the present credit and the incoming coin together decide the next credit and the outputs.

Once the credit plus the coin reaches twenty cents or more, the block vends the item. It signals any change on two lines, one for a returned nickel and one for a returned dime, and then goes back to zero credit to wait for the next sale. The largest possible change is fifteen cents, which is a nickel plus a dime. That cap applies even when a quarter arrives on top of 15 cents. All three outputs are registered pulses that last one cycle. The present credit is also brought out so the surrounding logic can show it.

Top module: `vend_ctrl`

## Requirements
- R1: A synchronous active-high reset forces the credit to 0 cents (credit code 00) and drives all three outputs low. Credit codes are 0¢=00, 5¢=01, 10¢=10 and 15¢=11.
- R2: Coin codes are nickel=00 (5¢), dime=01 (10¢) and quarter=10 (25¢). If a strobed coin leaves the total below twenty cents, the credit moves to the new total and no output is raised.
- R3: If a strobed coin brings the total to exactly twenty cents (10¢ + dime, 15¢ + nickel), the block raises dispense alone and the credit returns to 00.
- R4: If a strobed coin brings the total above twenty cents, the block raises dispense and returns the excess. 25¢ gives a nickel. 30¢ gives a dime. 35¢ gives a nickel and a dime. The credit returns to 00.
- R5: A quarter inserted at 15¢ (40¢ in total) raises dispense, return-nickel and return-dime. The change is capped at fifteen cents.
- R6: On an edge where the strobe is low, the credit holds and all outputs are low in the following cycle.
- R7: Coin code 11 is ignored even when strobed. The credit holds and all outputs are low.
- R8: A change return never occurs without dispense in the same cycle, and the change never exceeds fifteen cents.
- R9: The credit and the outputs update on the edge that accepts the coin, and each output pulse lasts exactly one cycle unless another vending coin is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_code | input | 2 | Coin type: 00 nickel, 01 dime, 10 quarter, 11 unused |
| coin_valid | input | 1 | Strobe: a coin is presented on this edge |
| credit | output | 2 | Present credit: 00 0¢, 01 5¢, 10 10¢, 11 15¢ |
| dispense | output | 1 | One-cycle pulse: release the item |
| ret_nickel | output | 1 | One-cycle pulse: return a nickel |
| ret_dime | output | 1 | One-cycle pulse: return a dime |

## Verification
Each result is due one register stage after its stimulus. The credit and all three outputs change on the same rising edge that samples the strobe and the coin code. The bench drives inputs on the falling edge and compares on the next falling edge, so exactly one rising edge falls between stimulus and check. It then presents an idle cycle and checks that the pulses have dropped. The sweep visits every credit value with every coin code, strobed and unstrobed. A long pseudo-random coin stream is then checked against an arithmetic model of credit plus coin value, minus the price, with the change capped.

// File: rtl/vend_pkg.sv
package vend_pkg;

    // Everything is counted in units of five cents.
    localparam int UNIT_CENTS   = 5;
    localparam int PRICE_CENTS  = 20;
    localparam int CHANGE_CENTS = 15;
    localparam int PRICE_UNITS  = PRICE_CENTS / UNIT_CENTS;
    localparam int CHANGE_UNITS = CHANGE_CENTS / UNIT_CENTS;
    localparam int CREDIT_W     = $clog2(PRICE_UNITS);
    localparam int COIN_W       = 2;
    localparam int COIN_UNITS_W = 3;
    localparam int SUM_W        = COIN_UNITS_W + 1;

    typedef enum logic [CREDIT_W-1:0] {
        CR_0  = 2'b00,
        CR_5  = 2'b01,
        CR_10 = 2'b10,
        CR_15 = 2'b11
    } credit_t;

    typedef enum logic [COIN_W-1:0] {
        COIN_NICKEL  = 2'b00,
        COIN_DIME    = 2'b01,
        COIN_QUARTER = 2'b10,
        COIN_NONE    = 2'b11
    } coin_t;

    typedef struct packed {
        logic dispense;
        logic ret_nickel;
        logic ret_dime;
    } vend_out_t;

    localparam vend_out_t OUT_IDLE = '{dispense: 1'b0, ret_nickel: 1'b0, ret_dime: 1'b0};

    typedef struct packed {
        credit_t   credit;
        vend_out_t out;
    } vend_step_t;

    function automatic logic [COIN_UNITS_W-1:0] coin_units(input coin_t c);
        case (c)
            COIN_NICKEL:  return COIN_UNITS_W'(1);
            COIN_DIME:    return COIN_UNITS_W'(2);
            COIN_QUARTER: return COIN_UNITS_W'(5);
            default:      return '0;
        endcase
    endfunction

endpackage

// File: rtl/vend_coin_gate.sv
module vend_coin_gate
    import vend_pkg::*;
(
    input  logic [COIN_W-1:0] coin_code,
    input  logic              coin_valid,
    output logic              accept,
    output coin_t             coin
);
    always_comb begin
        coin   = coin_t'(coin_code);
        accept = coin_valid && (coin != COIN_NONE);
    end
endmodule

// File: rtl/vend_step_logic.sv
module vend_step_logic
    import vend_pkg::*;
(
    input  credit_t    cur,
    input  coin_t      coin,
    output vend_step_t step
);
    logic [SUM_W-1:0] total;
    logic [SUM_W-1:0] excess;
    logic [SUM_W-1:0] change;

    always_comb begin
        total  = SUM_W'(cur) + SUM_W'(coin_units(coin));
        excess = total - SUM_W'(PRICE_UNITS);
        change = (excess > SUM_W'(CHANGE_UNITS)) ? SUM_W'(CHANGE_UNITS) : excess;
        if (total >= SUM_W'(PRICE_UNITS)) begin
            step.credit         = CR_0;
            step.out.dispense   = 1'b1;
            step.out.ret_nickel = change[0];
            step.out.ret_dime   = change[1];
        end else begin
            step.credit = credit_t'(total[CREDIT_W-1:0]);
            step.out    = OUT_IDLE;
        end
    end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] coin_code,
    input  logic       coin_valid,
    output logic [1:0] credit,
    output logic       dispense,
    output logic       ret_nickel,
    output logic       ret_dime
);
    credit_t    credit_q;
    vend_out_t  out_q;
    logic       accept;
    coin_t      coin;
    vend_step_t step;

    vend_coin_gate u_gate (
        .coin_code (coin_code),
        .coin_valid(coin_valid),
        .accept    (accept),
        .coin      (coin)
    );

    vend_step_logic u_step (
        .cur (credit_q),
        .coin(coin),
        .step(step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            credit_q <= CR_0;
            out_q    <= OUT_IDLE;
        end else if (accept) begin
            credit_q <= step.credit;
            out_q    <= step.out;
        end else begin
            out_q    <= OUT_IDLE;
        end
    end

    assign credit     = credit_q;
    assign dispense   = out_q.dispense;
    assign ret_nickel = out_q.ret_nickel;
    assign ret_dime   = out_q.ret_dime;
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] coin_code,
    input logic       coin_valid,
    input logic [1:0] credit,
    input logic       dispense,
    input logic       ret_nickel,
    input logic       ret_dime
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (credit == 2'b00) && !dispense && !ret_nickel && !ret_dime);

    a_r2_nickel_no_vend: assert property (@(posedge clk) disable iff (rst)
        (coin_valid && coin_code == 2'b00 && credit != 2'b11) |=>
            !dispense && (credit == $past(credit) + 2'b01));

    a_r3_vend_clears_credit: assert property (@(posedge clk) disable iff (rst)
        dispense |-> credit == 2'b00);

    a_r5_cap_on_forty: assert property (@(posedge clk) disable iff (rst)
        (coin_valid && coin_code == 2'b10 && credit == 2'b11) |=>
            dispense && ret_nickel && ret_dime);

    a_r6_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !coin_valid |=> $stable(credit) && !dispense && !ret_nickel && !ret_dime);

    a_r7_bad_code_ignored: assert property (@(posedge clk) disable iff (rst)
        (coin_valid && coin_code == 2'b11) |=>
            $stable(credit) && !dispense && !ret_nickel && !ret_dime);

    a_r8_change_needs_vend: assert property (@(posedge clk) disable iff (rst)
        (ret_nickel || ret_dime) |-> dispense);
endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .coin_code (coin_code),
    .coin_valid(coin_valid),
    .credit    (credit),
    .dispense  (dispense),
    .ret_nickel(ret_nickel),
    .ret_dime  (ret_dime)
);

// File: tb/sim_vend_ctrl.sv
module sim_vend_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] coin_code = 2'b00;
    logic       coin_valid = 1'b0;
    logic [1:0] credit;
    logic       dispense, ret_nickel, ret_dime;

    int checks = 0;
    int fails  = 0;
    int model_credit = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vend_ctrl u0 (
        .clk(clk), .rst(rst), .coin_code(coin_code), .coin_valid(coin_valid),
        .credit(credit), .dispense(dispense), .ret_nickel(ret_nickel), .ret_dime(ret_dime)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string req_of(input int code, input int valid, input int cents);
        if (!valid) return "R6";
        if (code == 3) return "R7";
        if (cents == 40) return "R5";
        if (cents > 20) return "R4";
        if (cents == 20) return "R3";
        return "R2";
    endfunction

    // Drive on a falling edge, compare on the next falling edge (R9).
    task automatic coin(input int code, input int valid);
        int cents, exp_out, chg;
        string req;
        @(negedge clk);
        coin_code  = 2'(code);
        coin_valid = valid[0];
        cents = model_credit * 5 + (code == 0 ? 5 : code == 1 ? 10 : code == 2 ? 25 : 0);
        req = req_of(code, valid, cents);
        exp_out = 0;
        if (valid && code != 3) begin
            if (cents >= 20) begin
                chg = cents - 20;
                if (chg > 15) chg = 15;
                exp_out = 4 + ((chg % 10) == 5 ? 2 : 0) + (chg >= 10 ? 1 : 0);
                model_credit = 0;
            end else begin
                model_credit = cents / 5;
            end
        end
        @(negedge clk);
        check(req, {29'd0, dispense, ret_nickel, ret_dime}, exp_out);
        check(req, int'(credit), model_credit);
        check("R8", int'((ret_nickel || ret_dime) && !dispense), 0);
        coin_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        coin_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        model_credit = 0;
        check("R1", int'(credit), 0);
        check("R1", {29'd0, dispense, ret_nickel, ret_dime}, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        int lfsr;
        int nxt;
        do_reset();
        // Sweep: every credit value with every coin code, strobed and not.
        for (int s = 0; s < 4; s++) begin
            for (int code = 0; code < 4; code++) begin
                for (int v = 0; v < 2; v++) begin
                    do_reset();
                    for (int k = 0; k < s; k++) coin(0, 1);
                    coin(code, v);
                    // Pulse must drop after one cycle (R9).
                    coin(0, 0);
                end
            end
        end
        // Back-to-back vending quarters: pulses stay high per accepted coin (R9).
        do_reset();
        coin(2, 1);
        coin(2, 1);
        coin(0, 0);
        // Reset in the middle of credit (R1).
        coin(1, 1);
        coin(0, 1);
        do_reset();
        // Pseudo-random coin stream checked against the model.
        lfsr = 32'h1d2c3b4a;
        for (int i = 0; i < 400; i++) begin
            nxt = lfsr ^ (lfsr << 13);
            nxt = nxt ^ (nxt >>> 17);
            nxt = nxt ^ (nxt << 5);
            lfsr = nxt;
            coin(lfsr & 3, ((lfsr >> 4) & 7) != 0 ? 1 : 0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule